// File: doc/BRIEF.md
# Sensor Burst Mode Scheduler

This block decides when a capacitive sensing front end launches its next measurement burst. The front end reports the end of each burst with a one-cycle done pulse. A detect integrator supplies two flags: one raised when a key might be touched, and one raised once such a candidate has been confirmed or discarded. An external SYNC line sets the pacing. SYNC held high gives a steady stream of fast bursts. SYNC held low gives low-power bursts separated by a long sleep. A pulse train on SYNC locks each burst to a rising edge.

SYNC is looked at only in the cycle where a burst ends, and that one sample picks the next mode. There is a single sleep phase. A synchronised rising edge of SYNC ends it and the block continues in locked mode. If the sleep timer runs out first, the block continues in low-power mode. In low-power mode a candidate touch switches the block to fast spacing until the integrator settles the candidate. The block then returns to the long sleep.

The controller has five states:
- BOOT: the reset state.
- LAUNCH: issues the burst-start pulse.
- MEASURE: waits for the done pulse.
- FAST_WAIT: the short gap between bursts.
- SLEEP: the long gap, which a SYNC rising edge can also end.

Transitions:
- BOOT to LAUNCH: always.
- LAUNCH to MEASURE: always.
- MEASURE to FAST_WAIT or SLEEP: on done, chosen by mode, the SYNC sample and the touch flags.
- FAST_WAIT to LAUNCH: on expiry of the fast timer.
- SLEEP to LAUNCH: on a SYNC rising edge, or on expiry of the sleep timer.

Top module: `burst_sched`

## Requirements
- R1: While `rst_n` is low, `burst_start_o` is 0 and `mode_o` is 0 (fast). The first start pulse is high in the first cycle after reset is released.
- R2: `burst_start_o` is high for exactly one cycle. After a start, no further start occurs until `burst_done_i` has been high for a cycle, however long that takes.
- R3: In fast mode (`mode_o`=0), a burst ending with the synchronised SYNC high keeps the mode at 0. The next start comes exactly FAST_CYC+1 cycles after the done cycle.
- R4: In fast mode, a burst ending with the synchronised SYNC low changes `mode_o` to 2 (locked) in the next cycle. No burst starts while SYNC stays low, until the sleep interval ends.
- R5: During the sleep phase, a rising edge on `sync_i` produces a start pulse exactly SYNC_STAGES+1 cycles after `sync_i` rises, with `mode_o`=2. Exactly one burst is started per edge.
- R6: A SYNC rising edge that occurs while a burst is in progress starts no burst, either then or afterwards.
- R7: If the sleep phase sees no SYNC rising edge, the next start comes exactly SLEEP_CYC+1 cycles after the done cycle, and `mode_o` becomes 1 (low power).
- R8: In low-power mode, a burst ending with SYNC low and `maybe_touch_i` low keeps the mode at 1 and sleeps SLEEP_CYC+1 cycles until the next start.
- R9: In low-power mode, a burst ending with SYNC low and `maybe_touch_i` high sets `mode_o` to 3 (escalated). The next start comes FAST_CYC+1 cycles after the done cycle.
- R10: In escalated mode, a burst ending with `touch_settled_i` low stays in mode 3 with fast spacing. A burst ending with `touch_settled_i` high returns to mode 1 with the SLEEP_CYC+1 spacing.
- R11: In low-power mode, a burst ending with SYNC high moves to mode 0 with FAST_CYC+1 spacing. This takes priority over `maybe_touch_i`.
- R12: In locked mode, every burst end keeps `mode_o` at 2 and enters the sleep phase, whatever the SYNC level and touch flags are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | External SYNC line, asynchronous to the clock |
| burst_done_i | input | 1 | One-cycle pulse marking the end of a burst |
| maybe_touch_i | input | 1 | Candidate touch, sampled in the done cycle |
| touch_settled_i | input | 1 | Candidate confirmed or rejected, sampled in the done cycle |
| burst_start_o | output | 1 | One-cycle pulse that launches a burst |
| mode_o | output | 2 | 0 fast, 1 low power, 2 locked, 3 escalated |

## Verification
The assertions check the following on every cycle:
- the start pulse is one cycle wide;
- the controller holds in MEASURE until done arrives;
- each end-of-burst mode decision;
- no start can follow directly from a burst in progress;
- a sleep phase ends in locked mode on an edge and in low-power mode on a timeout.

Only the bench's scenarios can show the exact spacing in cycles between bursts and the synchroniser latency from a pin edge to a start. They also show that an edge seen during a burst is lost for good, and how a touch candidate escalates and later returns to the long sleep.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

    typedef enum logic [1:0] {
        MODE_FAST   = 2'b00,
        MODE_LOWPWR = 2'b01,
        MODE_LOCKED = 2'b10,
        MODE_BOOST  = 2'b11
    } sched_mode_t;

    typedef enum logic [2:0] {
        ST_BOOT      = 3'd0,
        ST_LAUNCH    = 3'd1,
        ST_MEASURE   = 3'd2,
        ST_FAST_WAIT = 3'd3,
        ST_SLEEP     = 3'd4
    } sched_state_t;

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);

    // STAGES flops resynchronise the pin; one more flop remembers the
    // previous level so that a rising edge can be detected.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    end

    // R5: a detected edge lasts exactly one cycle
    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          last_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        last_o = (cnt_q == TW'(1));
    end

    // R7: the expiry indication cannot repeat without a reload
    a_r7_last_once: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i) |=> !last_o);

    // R3: an idle timer stays idle until it is loaded again
    a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/burst_sched_fsm.sv
module burst_sched_fsm
    import burst_sched_pkg::*;
#(
    parameter int FAST_CYC  = 20,
    parameter int SLEEP_CYC = 150,
    parameter int TW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_level_i,
    input  logic          sync_rise_i,
    input  logic          burst_done_i,
    input  logic          maybe_touch_i,
    input  logic          touch_settled_i,
    input  logic          timer_last_i,
    output logic          timer_load_o,
    output logic [TW-1:0] timer_val_o,
    output logic          burst_start_o,
    output logic [1:0]    mode_o
);

    localparam logic [TW-1:0] FAST_LOAD  = TW'(FAST_CYC);
    localparam logic [TW-1:0] SLEEP_LOAD = TW'(SLEEP_CYC);

    sched_state_t state_q, state_d;
    sched_mode_t  mode_q,  mode_d;

    // next state, next mode and timer reload
    always_comb begin
        state_d      = state_q;
        mode_d       = mode_q;
        timer_load_o = 1'b0;
        timer_val_o  = '0;
        unique case (state_q)
            ST_BOOT: begin
                state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (burst_done_i) begin
                    unique case (mode_q)
                        MODE_FAST: begin
                            if (sync_level_i) begin
                                state_d     = ST_FAST_WAIT;
                                timer_val_o = FAST_LOAD;
                            end else begin
                                mode_d      = MODE_LOCKED;
                                state_d     = ST_SLEEP;
                                timer_val_o = SLEEP_LOAD;
                            end
                        end
                        MODE_LOWPWR: begin
                            if (sync_level_i) begin
                                mode_d      = MODE_FAST;
                                state_d     = ST_FAST_WAIT;
                                timer_val_o = FAST_LOAD;
                            end else if (maybe_touch_i) begin
                                mode_d      = MODE_BOOST;
                                state_d     = ST_FAST_WAIT;
                                timer_val_o = FAST_LOAD;
                            end else begin
                                state_d     = ST_SLEEP;
                                timer_val_o = SLEEP_LOAD;
                            end
                        end
                        MODE_LOCKED: begin
                            state_d     = ST_SLEEP;
                            timer_val_o = SLEEP_LOAD;
                        end
                        MODE_BOOST: begin
                            if (touch_settled_i) begin
                                mode_d      = MODE_LOWPWR;
                                state_d     = ST_SLEEP;
                                timer_val_o = SLEEP_LOAD;
                            end else begin
                                state_d     = ST_FAST_WAIT;
                                timer_val_o = FAST_LOAD;
                            end
                        end
                        default: begin
                            mode_d = MODE_FAST;
                        end
                    endcase
                    timer_load_o = 1'b1;
                end
            end
            ST_FAST_WAIT: begin
                if (timer_last_i) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_SLEEP: begin
                if (sync_rise_i) begin
                    mode_d  = MODE_LOCKED;
                    state_d = ST_LAUNCH;
                end else if (timer_last_i) begin
                    mode_d  = MODE_LOWPWR;
                    state_d = ST_LAUNCH;
                end
            end
            default: begin
                state_d = ST_BOOT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            mode_q  <= MODE_FAST;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // outputs
    always_comb begin
        burst_start_o = (state_q == ST_LAUNCH);
        mode_o        = mode_q;
    end

    // R1: leaving reset leads straight to a start pulse
    a_r1_boot_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |=> burst_start_o);

    // R2: start is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_o |=> !burst_start_o);

    // R2: a running burst is held until done arrives
    a_r2_hold_measure: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !burst_done_i) |=> (state_q == ST_MEASURE));

    // R6: nothing launches directly out of a burst in progress
    a_r6_no_launch_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE) |=> !burst_start_o);

    // R3: fast mode with SYNC high keeps fast spacing
    a_r3_fast_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && burst_done_i && mode_q == MODE_FAST && sync_level_i)
        |=> (mode_o == MODE_FAST && state_q == ST_FAST_WAIT));

    // R4: fast mode with SYNC low goes to sleep in locked mode
    a_r4_enter_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && burst_done_i && mode_q == MODE_FAST && !sync_level_i)
        |=> (mode_o == MODE_LOCKED && state_q == ST_SLEEP));

    // R5: an edge during sleep launches a locked burst
    a_r5_edge_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && sync_rise_i)
        |=> (burst_start_o && mode_o == MODE_LOCKED));

    // R7: a timeout during sleep launches a low-power burst
    a_r7_timeout_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && timer_last_i && !sync_rise_i)
        |=> (burst_start_o && mode_o == MODE_LOWPWR));

    // R9: a candidate touch in low power escalates
    a_r9_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && burst_done_i && mode_q == MODE_LOWPWR
         && !sync_level_i && maybe_touch_i)
        |=> (mode_o == MODE_BOOST && state_q == ST_FAST_WAIT));

    // R10: a settled candidate returns to low power
    a_r10_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && burst_done_i && mode_q == MODE_BOOST && touch_settled_i)
        |=> (mode_o == MODE_LOWPWR && state_q == ST_SLEEP));

    // R11: SYNC high at the end of a low-power burst returns to fast mode
    a_r11_lp_to_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && burst_done_i && mode_q == MODE_LOWPWR && sync_level_i)
        |=> (mode_o == MODE_FAST));

    // R12: locked mode always sleeps after a burst
    a_r12_locked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && burst_done_i && mode_q == MODE_LOCKED)
        |=> (mode_o == MODE_LOCKED && state_q == ST_SLEEP));

endmodule

// File: rtl/burst_sched.sv
module burst_sched #(
    parameter int FAST_CYC    = 125000,
    parameter int SLEEP_CYC   = 10625000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic       burst_done_i,
    input  logic       maybe_touch_i,
    input  logic       touch_settled_i,
    output logic       burst_start_o,
    output logic [1:0] mode_o
);

    localparam int MAX_CYC = (FAST_CYC > SLEEP_CYC) ? FAST_CYC : SLEEP_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);

    logic          sync_level;
    logic          sync_rise;
    logic          timer_load;
    logic [TW-1:0] timer_val;
    logic          timer_last;

    sync_edge_det #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_i),
        .level_o (sync_level),
        .rise_o  (sync_rise)
    );

    interval_timer #(
        .TW (TW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .last_o     (timer_last)
    );

    burst_sched_fsm #(
        .FAST_CYC  (FAST_CYC),
        .SLEEP_CYC (SLEEP_CYC),
        .TW        (TW)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sync_level_i    (sync_level),
        .sync_rise_i     (sync_rise),
        .burst_done_i    (burst_done_i),
        .maybe_touch_i   (maybe_touch_i),
        .touch_settled_i (touch_settled_i),
        .timer_last_i    (timer_last),
        .timer_load_o    (timer_load),
        .timer_val_o     (timer_val),
        .burst_start_o   (burst_start_o),
        .mode_o          (mode_o)
    );

endmodule

// File: tb/burst_sched_test.sv
`timescale 1ns/1ps
module burst_sched_test;

    localparam int FAST  = 20;
    localparam int SLEEP = 150;
    localparam int STG   = 2;
    localparam int LAT   = STG + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b1;
    logic       done = 1'b0;
    logic       touch = 1'b0;
    logic       settled = 1'b0;
    logic       start;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    burst_sched #(
        .FAST_CYC    (FAST),
        .SLEEP_CYC   (SLEEP),
        .SYNC_STAGES (STG)
    ) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sync_i          (sync_i),
        .burst_done_i    (done),
        .maybe_touch_i   (touch),
        .touch_settled_i (settled),
        .burst_start_o   (start),
        .mode_o          (mode)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_eq(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // entered at the negedge that shows a start; ends at the negedge
    // just after the done cycle (offset 1)
    task automatic finish_burst(int dur, bit t, bit s);
        for (int i = 0; i < dur; i++) begin
            tick();
            check_eq("R2", "start during burst", int'(start), 0);
        end
        done = 1'b1;
        touch = t;
        settled = s;
        tick();
        done = 1'b0;
        touch = 1'b0;
        settled = 1'b0;
    endtask

    // entered at offset 1 after the done cycle; start expected at offset gap
    task automatic expect_gap(int gap, string tag);
        for (int k = 1; k < gap; k++) begin
            check_eq(tag, "early start", int'(start), 0);
            tick();
        end
        check_eq(tag, "start at gap", int'(start), 1);
    endtask

    // entered at offset 1 after the done cycle, SYNC low; raise it at offset o
    task automatic wake_after(int o, string tag);
        for (int k = 1; k < o; k++) begin
            check_eq(tag, "start before edge", int'(start), 0);
            tick();
        end
        sync_i = 1'b1;
        for (int k = 1; k < LAT; k++) begin
            tick();
            check_eq(tag, "start inside latency", int'(start), 0);
        end
        tick();
        check_eq(tag, "start after edge", int'(start), 1);
        check_eq(tag, "locked mode", int'(mode), 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset
        repeat (3) tick();
        check_eq("R1", "start in reset", int'(start), 0);
        check_eq("R1", "mode in reset", int'(mode), 0);
        rst_n = 1'b1;
        tick();
        check_eq("R1", "first start", int'(start), 1);
        check_eq("R1", "first mode", int'(mode), 0);
        tick();
        check_eq("R2", "pulse width", int'(start), 0);
        // back to the start negedge is not possible; finish this burst
        finish_burst(4, 1'b0, 1'b0);
        check_eq("R3", "fast mode kept", int'(mode), 0);
        expect_gap(FAST + 1, "R3");

        // R2/R3 sweep of burst lengths, touch flags irrelevant in fast mode
        for (int d = 1; d <= 12; d++) begin
            finish_burst(d, d[0], d[1]);
            check_eq("R3", "fast mode kept", int'(mode), 0);
            expect_gap(FAST + 1, "R3");
        end

        // R4 fast with SYNC low enters locked sleep, R5 edge wakes it
        sync_i = 1'b0;
        finish_burst(5, 1'b0, 1'b0);
        check_eq("R4", "locked after low sample", int'(mode), 2);
        wake_after(12, "R5");

        // R6 edge during burst ignored; R12 locked stays; R7 timeout
        for (int i = 0; i < 3; i++) begin
            tick();
            check_eq("R6", "start during burst edge", int'(start), 0);
        end
        sync_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check_eq("R6", "start during burst edge", int'(start), 0);
        end
        sync_i = 1'b1;
        finish_burst(5, 1'b1, 1'b0);
        check_eq("R12", "locked kept", int'(mode), 2);
        expect_gap(SLEEP + 1, "R6");
        check_eq("R7", "low power after timeout", int'(mode), 1);

        // R8 low power sleep
        sync_i = 1'b0;
        finish_burst(5, 1'b0, 1'b0);
        check_eq("R8", "low power kept", int'(mode), 1);
        expect_gap(SLEEP + 1, "R8");

        // R9 escalation
        finish_burst(4, 1'b1, 1'b0);
        check_eq("R9", "escalated", int'(mode), 3);
        expect_gap(FAST + 1, "R9");

        // R10 unresolved keeps fast spacing
        for (int i = 0; i < 3; i++) begin
            finish_burst(3 + i, 1'b1, 1'b0);
            check_eq("R10", "still escalated", int'(mode), 3);
            expect_gap(FAST + 1, "R10");
        end
        finish_burst(3, 1'b0, 1'b1);
        check_eq("R10", "back to low power", int'(mode), 1);
        expect_gap(SLEEP + 1, "R10");

        // R5 sweep over the edge position inside the sleep phase
        for (int o = 1; o <= 30; o++) begin
            sync_i = 1'b0;
            finish_burst(5, 1'b0, 1'b0);
            check_eq("R5", "mode during sleep", int'(mode), (o == 1) ? 1 : 2);
            wake_after(o, "R5");
        end

        // R12 with SYNC high and both touch flags set
        finish_burst(5, 1'b1, 1'b1);
        check_eq("R12", "locked kept", int'(mode), 2);
        expect_gap(SLEEP + 1, "R12");
        check_eq("R7", "low power after timeout", int'(mode), 1);

        // R11 SYNC high wins over a candidate touch
        finish_burst(4, 1'b1, 1'b0);
        check_eq("R11", "fast after high sample", int'(mode), 0);
        expect_gap(FAST + 1, "R11");
        finish_burst(2, 1'b0, 1'b0);
        check_eq("R3", "fast mode kept", int'(mode), 0);
        expect_gap(FAST + 1, "R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule